// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port with Bit Compare

This block is an 8-bit clock-synchronous serial port. It shifts a data byte out on one pin and shifts a byte in on another pin, using a serial clock that it either makes itself or takes from an external pin. When the block makes the clock, it divides the system clock by a programmable power of two, and writing the data register starts a transfer. When the clock comes from outside, the data register moves by one bit on every clock edge pair that arrives, and completion is reported every programmed number of bits. Software sets a transfer length of 1 to 8 bits and chooses which end of the byte goes first.

The serial output has an enable that goes low at the end of a transfer in internal-clock mode. In external-clock mode, software can float the output between transfers, and the next transfer drives it again. An optional compare function checks the bit sent against the bit received on every rising serial clock. Its result appears on a pin, and the block can raise an event on a selectable edge of that pin. Software reaches two control registers and the data register over a simple single-cycle register bus.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, all three registers read 0, sclkOut is 1, and sdoOe, cmpOut, doneIrq and cmpIrq are 0.
- R2: Register address 0 holds clkDiv in bits [2:0], msbFirst in bit 3 and intClk in bit 4 (1 = internal clock, 0 = sclkIn). In internal mode each half period of sclkOut lasts 4, 8, 16, 32, 64 or 128 system clocks for clkDiv codes 000, 001, 010, 011, 110 and 111. The reserved codes 100 and 101 behave as 111.
- R3: In internal mode, writing address 2 (data) while idle starts a transfer. The busy bit, address 1 bit 7, reads 1 from that write until completion.
- R4: A write to the data register while busy is ignored: the transfer and the final received byte are those of the original data.
- R5: Address 1 bits [2:0] (lenSel) set the transfer length to lenSel+1 bits. doneIrq is a one-cycle pulse raised on the system clock edge that handles the last rising serial edge, and busy clears on that same edge.
- R6: With msbFirst=0, bit 0 is sent first, and received bits enter at bit 7 while the register shifts right. With msbFirst=1, bit 7 is sent first, and received bits enter at bit 0 while the register shifts left. After an n-bit transfer, the older contents stay in the other positions, shifted by n.
- R7: sdo changes only on a falling serial edge, and sdi is sampled on a rising serial edge. The internal clock sclkOut idles high, and sclkOe is 1 exactly when intClk is 1.
- R8: In internal mode, sdoOe goes to 0 on completion, and the software float bit (address 1 bit 4) stays 0.
- R9: In external mode, the port shifts on every incoming clock with no stop. It pulses doneIrq after each lenSel+1 bits, and sdoOe stays 1 after completion.
- R10: Writing 1 to the float bit forces sdoOe to 0. The first falling serial edge after that clears the bit, and sdoOe returns to 1.
- R11: When cmpEn (address 1 bit 3) is 1, on each rising serial edge cmpOut takes the value 1 if the sdo level differs from sdi and 0 if they are equal. When cmpEn is 0, cmpOut is 0.
- R12: cmpIrq pulses for one cycle when cmpOut rises (cmpEdge, address 1 bit 5, is 0) or when it falls (cmpEdge is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Register write strobe |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data (combinational) |
| sclkIn | input | 1 | External serial clock |
| sclkOut | output | 1 | Internally generated serial clock |
| sclkOe | output | 1 | Drive enable for sclkOut |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output level |
| sdoOe | output | 1 | Drive enable for sdo |
| cmpOut | output | 1 | Sent/received compare result |
| doneIrq | output | 1 | Transfer completion pulse |
| cmpIrq | output | 1 | Compare edge event pulse |

## Verification
The assertions assume that software changes the clock source only while the port is idle. They also assume that an external serial clock stays at each level for several system clocks, so that no two synchronized edges fall on adjacent cycles. The bench switches modes only between transfers and holds each sclkIn level for six system clocks. Its random internal-clock transfers use the two fastest divider codes, with random data, length, bit order and loopback inversion.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] ADDR_CTRLA = 2'd0;
  localparam logic [1:0] ADDR_CTRLB = 2'd1;
  localparam logic [1:0] ADDR_DATA  = 2'd2;

  typedef struct packed {
    logic loadData;
    logic shiftOut;
    logic shiftIn;
    logic msbFirst;
    logic cmpEn;
    logic cmpEdge;
  } sspStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BASE_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] srData,
  input  logic              sclkIn,
  output logic [DATA_W-1:0] busRdata,
  output sspStrobe_t        strobe,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              sdoOe,
  output logic              doneIrq
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int PH_W  = $clog2(BASE_HALF << 5) + 1;

  logic [2:0]       clkDiv;
  logic             msbFirst, intClk;
  logic [CNT_W-1:0] lenSel, bitCnt;
  logic             cmpEn, sdoFloat, cmpEdge;
  logic             busy, driveEn, sclkInt;
  logic [PH_W-1:0]  phaseCnt, halfLim;
  logic             sync1, sync2, sclkPrev;
  logic             wrData, wrCtrlA, wrCtrlB, tick, fallEv, riseEv;
  logic [2:0]       divShift;
  wire unusedHi = &{1'b0, busWdata[DATA_W-1:6]};

  // Divider code to shift amount; reserved codes fold onto the slowest rate
  always_comb begin
    if (!clkDiv[2])             divShift = {1'b0, clkDiv[1:0]};
    else if (clkDiv[1:0] == 2'b10) divShift = 3'd4;
    else                        divShift = 3'd5;
    halfLim = PH_W'(BASE_HALF) << divShift;
  end

  assign wrCtrlA = busWr && (busAddr == ADDR_CTRLA);
  assign wrCtrlB = busWr && (busAddr == ADDR_CTRLB);
  assign wrData  = busWr && (busAddr == ADDR_DATA) && !busy;
  assign tick    = busy && intClk && (phaseCnt == halfLim - 1'b1);
  assign fallEv  = intClk ? (tick && sclkInt)  : (sclkPrev && !sync2);
  assign riseEv  = intClk ? (tick && !sclkInt) : (!sclkPrev && sync2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkDiv <= '0; msbFirst <= 1'b0; intClk <= 1'b0;
      lenSel <= '0; cmpEn <= 1'b0; sdoFloat <= 1'b0; cmpEdge <= 1'b0;
      busy <= 1'b0; driveEn <= 1'b0; sclkInt <= 1'b1;
      phaseCnt <= '0; bitCnt <= '0; doneIrq <= 1'b0;
      sync1 <= 1'b1; sync2 <= 1'b1; sclkPrev <= 1'b1;
    end else begin
      sync1    <= sclkIn;
      sync2    <= sync1;
      sclkPrev <= sync2;
      doneIrq  <= 1'b0;
      if (wrCtrlA) begin
        clkDiv   <= busWdata[2:0];
        msbFirst <= busWdata[3];
        intClk   <= busWdata[4];
      end
      if (wrCtrlB) begin
        lenSel   <= busWdata[CNT_W-1:0];
        cmpEn    <= busWdata[3];
        sdoFloat <= busWdata[4];
        cmpEdge  <= busWdata[5];
      end
      if (wrData && intClk) begin
        busy     <= 1'b1;
        driveEn  <= 1'b1;
        phaseCnt <= '0;
        bitCnt   <= '0;
        sclkInt  <= 1'b1;
      end else if (busy && intClk) begin
        if (tick) begin
          phaseCnt <= '0;
          sclkInt  <= ~sclkInt;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
      if (fallEv) begin
        busy     <= 1'b1;
        driveEn  <= 1'b1;
        sdoFloat <= 1'b0;
      end
      if (riseEv) begin
        if (bitCnt == lenSel) begin
          bitCnt  <= '0;
          busy    <= 1'b0;
          doneIrq <= 1'b1;
          if (intClk) driveEn <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.loadData = wrData;
    strobe.shiftOut = fallEv;
    strobe.shiftIn  = riseEv;
    strobe.msbFirst = msbFirst;
    strobe.cmpEn    = cmpEn;
    strobe.cmpEdge  = cmpEdge;
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRLA: busRdata = DATA_W'({intClk, msbFirst, clkDiv});
      ADDR_CTRLB: busRdata = DATA_W'({busy, 1'b0, cmpEdge, sdoFloat, cmpEn, 3'(lenSel)});
      ADDR_DATA:  busRdata = srData;
      default:    busRdata = '0;
    endcase
  end

  assign sclkOut = sclkInt;
  assign sclkOe  = intClk;
  assign sdoOe   = driveEn && !sdoFloat;
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdi,
  output logic [DATA_W-1:0] srData,
  output logic              sdo,
  output logic              cmpOut,
  output logic              cmpIrq
);
  logic [DATA_W-1:0] shiftReg;
  logic              sdoReg, cmpNew;

  assign cmpNew = sdoReg ^ sdi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= 1'b1;
    end else begin
      if (strobe.loadData)
        shiftReg <= wrData;
      else if (strobe.shiftIn)
        shiftReg <= strobe.msbFirst ? {shiftReg[DATA_W-2:0], sdi}
                                    : {sdi, shiftReg[DATA_W-1:1]};
      if (strobe.shiftOut)
        sdoReg <= strobe.msbFirst ? shiftReg[DATA_W-1] : shiftReg[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpOut <= 1'b0;
      cmpIrq <= 1'b0;
    end else begin
      cmpIrq <= 1'b0;
      if (!strobe.cmpEn) begin
        cmpOut <= 1'b0;
      end else if (strobe.shiftIn) begin
        cmpOut <= cmpNew;
        cmpIrq <= strobe.cmpEdge ? (cmpOut & ~cmpNew) : (~cmpOut & cmpNew);
      end
    end
  end

  assign srData = shiftReg;
  assign sdo    = sdoReg;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BASE_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  output logic              cmpOut,
  output logic              doneIrq,
  output logic              cmpIrq
);
  sspStrobe_t        strobe;
  logic [DATA_W-1:0] srData;

  ssp_ctrl #(.DATA_W(DATA_W), .BASE_HALF(BASE_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .srData(srData), .sclkIn(sclkIn),
    .busRdata(busRdata), .strobe(strobe), .sclkOut(sclkOut),
    .sclkOe(sclkOe), .sdoOe(sdoOe), .doneIrq(doneIrq)
  );

  ssp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWdata),
    .sdi(sdi), .srData(srData), .sdo(sdo), .cmpOut(cmpOut), .cmpIrq(cmpIrq)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rstN,
  input logic sclkOut,
  input logic sclkOe,
  input logic sdo,
  input logic sdoOe,
  input logic cmpOut,
  input logic doneIrq,
  input logic cmpIrq
);
  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R7: internal clock is back high when a transfer completes
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && sclkOe) |-> sclkOut);

  // R7: in internal mode sdo only moves while the serial clock is low
  a_r7_sdo_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOe && !$stable(sdo)) |-> !sclkOut);

  // R8: internal-mode completion releases the output
  a_r8_auto_float: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && sclkOe) |-> !sdoOe);

  // R12: a compare event coincides with a change of the compare pin
  a_r12_cmp_edge: assert property (@(posedge clk) disable iff (!rstN)
    cmpIrq |-> (cmpOut != $past(cmpOut)));

  // R12: compare event is a single-cycle pulse
  a_r12_cmp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmpIrq |=> !cmpIrq);
endmodule

bind sync_serial_port ssp_checker u_chk (
  .clk(clk), .rstN(rstN), .sclkOut(sclkOut), .sclkOe(sclkOe), .sdo(sdo),
  .sdoOe(sdoOe), .cmpOut(cmpOut), .doneIrq(doneIrq), .cmpIrq(cmpIrq)
);

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sclkIn = 1'b1;
  logic       sclkOut, sclkOe, sdi, sdo, sdoOe, cmpOut, doneIrq, cmpIrq;
  logic       flip = 1'b0;

  int checkCnt = 0, failCnt = 0;
  int doneCnt = 0, cmpIrqCnt = 0, lowCnt = 0;

  assign sdi = sdo ^ flip;

  sync_serial_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .sdi(sdi), .sdo(sdo),
    .sdoOe(sdoOe), .cmpOut(cmpOut), .doneIrq(doneIrq), .cmpIrq(cmpIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (doneIrq) doneCnt++;
    if (cmpIrq)  cmpIrqCnt++;
  end
  always @(negedge clk) if (sclkOe && !sclkOut) lowCnt++;

  function automatic logic [7:0] expShift(input logic [7:0] d, input int n,
                                          input logic msb, input logic fl);
    logic [7:0] s = d;
    for (int i = 0; i < n; i++) begin
      logic o = msb ? s[7] : s[0];
      logic b = o ^ fl;
      s = msb ? {s[6:0], b} : {b, s[7:1]};
    end
    return s;
  endfunction

  function automatic int halfOf(input logic [2:0] code);
    case (code)
      3'b000: return 4;
      3'b001: return 8;
      3'b010: return 16;
      3'b011: return 32;
      3'b110: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitDone(input int target);
    int t = 0;
    while (doneCnt < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    checkEq("R5 completion seen", doneCnt >= target, 1);
  endtask

  task automatic runInt(input logic [7:0] d, input logic [2:0] len, input logic msb,
                        input logic fl, input logic [2:0] div, input logic [7:0] ctrlB);
    int target;
    busWrite(2'd1, {ctrlB[7:3], len});
    busWrite(2'd0, {3'b000, 1'b1, msb, div});
    flip = fl;
    target = doneCnt + 1;
    busWrite(2'd2, d);
    waitDone(target);
    repeat (2) @(negedge clk);
  endtask

  task automatic extBit(input logic checkFloat);
    logic [7:0] r;
    @(negedge clk) sclkIn = 1'b0;
    repeat (6) @(negedge clk);
    if (checkFloat) begin
      busRead(2'd1, r);
      checkEq("R10 float bit cleared by falling edge", r[4], 0);
      checkEq("R10 sdoOe driven again", sdoOe, 1);
    end
    sclkIn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++; checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [7:0] r, d, exp;
    int l0, base;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd0, r); checkEq("R1 ctrlA reset", r, 0);
    busRead(2'd1, r); checkEq("R1 ctrlB reset", r, 0);
    busRead(2'd2, r); checkEq("R1 data reset", r, 0);
    checkEq("R1 sclkOut idle", sclkOut, 1);
    checkEq("R1 outputs idle", {sdoOe, cmpOut, doneIrq, cmpIrq}, 0);

    // R7 first sent bit appears after the first falling edge, LSB first
    busWrite(2'd1, 8'h07);
    busWrite(2'd0, 8'h10);
    flip = 1'b0;
    base = doneCnt;
    busWrite(2'd2, 8'hB6);
    checkEq("R7 sclkOe in internal mode", sclkOe, 1);
    busRead(2'd1, r); checkEq("R3 busy after data write", r[7], 1);
    // R4 write while busy is ignored
    busWrite(2'd2, 8'h00);
    @(negedge sclkOut); @(negedge clk);
    checkEq("R7 sdo after first fall", sdo, 0);
    @(negedge sclkOut); @(negedge clk);
    checkEq("R7 second bit", sdo, 1);
    waitDone(base + 1);
    repeat (2) @(negedge clk);
    busRead(2'd2, r); checkEq("R4 data unaffected by busy write", r, expShift(8'hB6, 8, 0, 0));
    busRead(2'd1, r);
    checkEq("R3 busy cleared", r[7], 0);
    checkEq("R8 float bit stays 0", r[4], 0);
    checkEq("R8 sdoOe released", sdoOe, 0);
    checkEq("R7 clock idles high", sclkOut, 1);
    checkEq("R5 exactly one pulse", doneCnt - base, 1);

    // R2 divider codes, measured as low-phase length of a 1-bit transfer
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 5 || c == 7) continue;
      l0 = lowCnt;
      runInt(8'h5A, 3'd0, 1'b0, 1'b0, 3'(c), 8'h00);
      checkEq($sformatf("R2 half period code %0d", c), lowCnt - l0, halfOf(3'(c)));
    end

    // R6 partial transfers, both orders
    runInt(8'hC3, 3'd2, 1'b0, 1'b1, 3'd0, 8'h00);
    busRead(2'd2, r); checkEq("R6 LSB-first 3-bit placement", r, expShift(8'hC3, 3, 0, 1));
    runInt(8'hC3, 3'd4, 1'b1, 1'b1, 3'd0, 8'h00);
    busRead(2'd2, r); checkEq("R6 MSB-first 5-bit placement", r, expShift(8'hC3, 5, 1, 1));

    // Random internal transfers (R5, R6)
    for (int i = 0; i < 24; i++) begin
      logic [2:0] len;
      logic msb, fl, dv;
      d = 8'($urandom); len = 3'($urandom); msb = 1'($urandom);
      fl = 1'($urandom); dv = 1'($urandom);
      base = doneCnt;
      runInt(d, len, msb, fl, {2'b00, dv}, 8'h00);
      busRead(2'd2, r);
      checkEq("R6 random received byte", r, expShift(d, int'(len) + 1, msb, fl));
      checkEq("R5 random single completion", doneCnt - base, 1);
    end

    // R11 compare disabled then enabled, R12 rising-edge event
    runInt(8'h3C, 3'd7, 1'b0, 1'b1, 3'd0, 8'h00);
    checkEq("R11 cmpOut 0 while disabled", cmpOut, 0);
    base = cmpIrqCnt;
    runInt(8'h3C, 3'd7, 1'b0, 1'b1, 3'd0, 8'h08);
    checkEq("R11 mismatch gives 1", cmpOut, 1);
    checkEq("R12 one rising event", cmpIrqCnt - base, 1);
    base = cmpIrqCnt;
    runInt(8'h3C, 3'd7, 1'b0, 1'b0, 3'd0, 8'h08);
    checkEq("R11 match gives 0", cmpOut, 0);
    checkEq("R12 no event on fall with rising select", cmpIrqCnt - base, 0);
    runInt(8'h3C, 3'd7, 1'b0, 1'b1, 3'd0, 8'h28);
    base = cmpIrqCnt;
    runInt(8'h3C, 3'd7, 1'b0, 1'b0, 3'd0, 8'h28);
    checkEq("R12 falling-select event", cmpIrqCnt - base, 1);

    // R9 external clock: 4-bit length, 8 clocks, continuous shifting
    busWrite(2'd1, 8'h03);
    busWrite(2'd0, 8'h00);
    checkEq("R7 sclkOe off in external mode", sclkOe, 0);
    busWrite(2'd2, 8'hA5);
    flip = 1'b1;
    base = doneCnt;
    for (int b = 0; b < 8; b++) extBit(1'b0);
    repeat (2) @(negedge clk);
    checkEq("R9 two completions over 8 clocks", doneCnt - base, 2);
    checkEq("R9 sdoOe stays driven", sdoOe, 1);
    busRead(2'd2, r);
    exp = expShift(8'hA5, 8, 0, 1);
    checkEq("R9 external received byte", r, exp);

    // R10 software float and release by next falling edge
    busWrite(2'd1, 8'h13);
    checkEq("R10 float forces sdoOe low", sdoOe, 0);
    busRead(2'd1, r); checkEq("R10 float bit set", r[4], 1);
    extBit(1'b1);
    for (int b = 0; b < 3; b++) extBit(1'b0);
    repeat (2) @(negedge clk);
    checkEq("R9 third completion", doneCnt - base, 3);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule